// File: doc/BRIEF.md
# USB Host Control Registers and Frame Timer

This block is the software-facing control and status front of a minimal full-speed USB host. It sits on a simple word-addressed bus slave port, and read data follows the address combinationally. Three functions live behind three word offsets. The first holds control bits that put the cable into bus reset, enable start-of-frame generation and request a flush of the transmit FIFO. The second is a three-source interrupt controller with separate pending, mask and write-one-to-clear acknowledge registers. The third is a readable status word.

A free-running frame counter in the 48 MHz domain counts out the one-millisecond frame. When enabled, it asks the transaction engine to send a start-of-frame token each time it wraps, and its count is readable as the frame time. The block also samples the PHY line state and holds a sticky receive-error flag. The packet engine, the FIFOs and the PHY are separate blocks. They talk to this one only through single-cycle strobes and status inputs.

Top module: `uhost_csr`

## Requirements
- R1: A bus write to word 0 loads `bus_reset_o` from data bit 0 and the start-of-frame enable from data bit 1, effective the cycle after the write. Both are 0 after reset.
- R2: The frame time counts up by one each clock from 0 to FRAME_CYCLES-1 and then returns to 0. FRAME_CYCLES is 48000 by default. A read of word 0 returns the frame time in bits 31:16.
- R3: `sof_req_o` is high for exactly one cycle, the cycle in which the frame time reads 0 after a wrap. It is high only if, in the cycle before, start-of-frame was enabled and bus reset was inactive.
- R4: The PHY line state is registered every clock and appears in bits 1:0 of word 0 (bit 1 = D-, bit 0 = D+) one cycle after it is presented.
- R5: Bit 2 of word 0 is a sticky receive-error flag. `rx_err_i` sets it and `xfer_start_i` clears it. If both arrive in the same cycle, the flag is set.
- R6: A read of word 1 returns the pending interrupts in bits 2:0: bit 2 = error (`xfer_err_i`), bit 1 = transfer done (`xfer_done_i`), bit 0 = start of frame (set the cycle after `sof_req_o`). Writing a 1 to a bit of word 1 clears that pending bit. Writing a 0 leaves it unchanged.
- R7: If an interrupt event and an acknowledge of the same bit occur in the same cycle, the bit ends up set.
- R8: Word 2 is a read/write 3-bit mask with the same bit order as the pending bits, 0 after reset. `irq_o` is high whenever any pending bit has its mask bit set.
- R9: Writing word 0 with data bit 2 set drives `tx_flush_o` high for exactly the following cycle. The flush request is not stored.
- R10: Reads of any word other than 0, 1 and 2 return zero, and writes there change no state. `bus_rdata_o` is zero while `bus_sel_i` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 48 MHz block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel_i | input | 1 | Bus access select |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | ADDR_W | Byte address; bits 1:0 ignored |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Combinational read data |
| line_state_i | input | 2 | PHY line state (bit 1 D-, bit 0 D+) |
| rx_err_i | input | 1 | Receive error strobe from PHY |
| xfer_start_i | input | 1 | New transfer start strobe |
| xfer_done_i | input | 1 | Transfer completion event |
| xfer_err_i | input | 1 | Transfer error event |
| bus_reset_o | output | 1 | Hold the USB bus in reset |
| sof_req_o | output | 1 | One-cycle start-of-frame token request |
| tx_flush_o | output | 1 | One-cycle transmit FIFO flush |
| irq_o | output | 1 | Masked interrupt request |

## Verification
The bench runs two kinds of traffic. The scripted part isolates single behaviours: a frame with generation enabled and one with bus reset held, which shows the gating of the start-of-frame request; an acknowledge written in the same cycle as a done event, which shows that the event wins over the clear; receive error and transfer start arriving together; and writes to an unused word followed by reads of every word. The random part mixes reads, writes to all offsets and asynchronous event strobes over many frames. It catches ordering faults between the counter wrap, the start-of-frame pending bit and the mask. A small frame length keeps many wraps inside the run.

// File: rtl/uhost_csr_pkg.sv
package uhost_csr_pkg;
  localparam int DATA_W   = 32;
  localparam int IRQ_N    = 3;
  localparam int IRQ_SOF  = 0;
  localparam int IRQ_DONE = 1;
  localparam int IRQ_ERR  = 2;
  localparam int TIME_LSB = 16;

  typedef enum logic [1:0] {
    RSEL_CTRL = 2'd0,
    RSEL_IRQ  = 2'd1,
    RSEL_MASK = 2'd2,
    RSEL_NONE = 2'd3
  } reg_sel_e;

  function automatic reg_sel_e decode_word(input int unsigned word);
    case (word)
      0:       decode_word = RSEL_CTRL;
      1:       decode_word = RSEL_IRQ;
      2:       decode_word = RSEL_MASK;
      default: decode_word = RSEL_NONE;
    endcase
  endfunction
endpackage

// File: rtl/uhost_frame_timer.sv
module uhost_frame_timer #(
  parameter int FRAME_CYCLES = 48000,
  parameter int TIME_W       = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sof_en_i,
  input  logic              bus_rst_i,
  output logic [TIME_W-1:0] time_o,
  output logic              sof_req_o
);
  localparam logic [TIME_W-1:0] LAST = TIME_W'(FRAME_CYCLES - 1);

  logic [TIME_W-1:0] cnt_q, cnt_d;
  logic              sof_q, sof_d;
  logic              at_last;

  assign at_last = (cnt_q == LAST);

  always_comb begin
    cnt_d = at_last ? '0 : cnt_q + 1'b1;
    sof_d = at_last && sof_en_i && !bus_rst_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sof_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      sof_q <= sof_d;
    end
  end

  assign time_o    = cnt_q;
  assign sof_req_o = sof_q;

  p_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    at_last |=> (time_o == '0));
  p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !at_last |=> (time_o == $past(time_o) + 1'b1));
  p_sof_at_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sof_req_o |-> (time_o == '0));
  p_sof_gated_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rst_i || !sof_en_i) |=> !sof_req_o);
endmodule

// File: rtl/uhost_irq_unit.sv
module uhost_irq_unit #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] evt_i,
  input  logic [N-1:0] ack_i,
  input  logic         mask_we_i,
  input  logic [N-1:0] mask_wdata_i,
  output logic [N-1:0] pend_o,
  output logic [N-1:0] mask_o,
  output logic         irq_o
);
  logic [N-1:0] pend_q, pend_d;
  logic [N-1:0] mask_q, mask_d;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      pend_d[i] = evt_i[i] | (pend_q[i] & ~ack_i[i]);
    end
    mask_d = mask_we_i ? mask_wdata_i : mask_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      mask_q <= '0;
    end else begin
      pend_q <= pend_d;
      if (mask_we_i) mask_q <= mask_d;
    end
  end

  assign pend_o = pend_q;
  assign mask_o = mask_q;
  assign irq_o  = |(pend_q & mask_q);

  p_ack_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((ack_i & ~evt_i) != '0) |=> ((pend_o & $past(ack_i & ~evt_i)) == '0));
  p_event_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_i != '0) |=> ((pend_o & $past(evt_i)) == $past(evt_i)));
  p_mask_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !mask_we_i |=> $stable(mask_o));
endmodule

// File: rtl/uhost_phy_status.sv
module uhost_phy_status (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] line_i,
  input  logic       rx_err_i,
  input  logic       xfer_start_i,
  output logic [1:0] line_o,
  output logic       rx_err_o
);
  logic [1:0] line_q;
  logic       err_q, err_d;

  always_comb begin
    if (rx_err_i)          err_d = 1'b1;
    else if (xfer_start_i) err_d = 1'b0;
    else                   err_d = err_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q <= 2'b00;
      err_q  <= 1'b0;
    end else begin
      line_q <= line_i;
      err_q  <= err_d;
    end
  end

  assign line_o   = line_q;
  assign rx_err_o = err_q;

  p_err_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_start_i && !rx_err_i) |=> !rx_err_o);
  p_err_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_err_i |=> rx_err_o);
endmodule

// File: rtl/uhost_csr.sv
module uhost_csr
  import uhost_csr_pkg::*;
#(
  parameter int ADDR_W       = 8,
  parameter int FRAME_CYCLES = 48000,
  parameter int TIME_W       = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [31:0]       bus_wdata_i,
  output logic [31:0]       bus_rdata_o,
  input  logic [1:0]        line_state_i,
  input  logic              rx_err_i,
  input  logic              xfer_start_i,
  input  logic              xfer_done_i,
  input  logic              xfer_err_i,
  output logic              bus_reset_o,
  output logic              sof_req_o,
  output logic              tx_flush_o,
  output logic              irq_o
);
  localparam int WORD_W = ADDR_W - 2;

  reg_sel_e          rsel;
  logic              wr_en, wr_ctrl, wr_irq, wr_mask;
  logic              brst_q, brst_d, sof_en_q, sof_en_d, flush_q, flush_d;
  logic [TIME_W-1:0] frame_time;
  logic [1:0]        line_st;
  logic              rx_err_flag;
  logic [IRQ_N-1:0]  evt, ack, pend, mask;
  logic [WORD_W-1:0] word;

  assign word    = bus_addr_i[ADDR_W-1:2];
  assign rsel    = decode_word(int'(word));
  assign wr_en   = bus_sel_i && bus_we_i;
  assign wr_ctrl = wr_en && (rsel == RSEL_CTRL);
  assign wr_irq  = wr_en && (rsel == RSEL_IRQ);
  assign wr_mask = wr_en && (rsel == RSEL_MASK);

  always_comb begin
    brst_d   = wr_ctrl ? bus_wdata_i[0] : brst_q;
    sof_en_d = wr_ctrl ? bus_wdata_i[1] : sof_en_q;
    flush_d  = wr_ctrl && bus_wdata_i[2];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      brst_q   <= 1'b0;
      sof_en_q <= 1'b0;
      flush_q  <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        brst_q   <= brst_d;
        sof_en_q <= sof_en_d;
      end
      flush_q <= flush_d;
    end
  end

  uhost_frame_timer #(.FRAME_CYCLES(FRAME_CYCLES), .TIME_W(TIME_W)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .sof_en_i  (sof_en_q),
    .bus_rst_i (brst_q),
    .time_o    (frame_time),
    .sof_req_o (sof_req_o)
  );

  uhost_phy_status u_phy_status (
    .clk          (clk),
    .rst_n        (rst_n),
    .line_i       (line_state_i),
    .rx_err_i     (rx_err_i),
    .xfer_start_i (xfer_start_i),
    .line_o       (line_st),
    .rx_err_o     (rx_err_flag)
  );

  always_comb begin
    evt           = '0;
    evt[IRQ_SOF]  = sof_req_o;
    evt[IRQ_DONE] = xfer_done_i;
    evt[IRQ_ERR]  = xfer_err_i;
    ack           = wr_irq ? bus_wdata_i[IRQ_N-1:0] : '0;
  end

  uhost_irq_unit #(.N(IRQ_N)) u_irq (
    .clk          (clk),
    .rst_n        (rst_n),
    .evt_i        (evt),
    .ack_i        (ack),
    .mask_we_i    (wr_mask),
    .mask_wdata_i (bus_wdata_i[IRQ_N-1:0]),
    .pend_o       (pend),
    .mask_o       (mask),
    .irq_o        (irq_o)
  );

  always_comb begin
    bus_rdata_o = '0;
    if (bus_sel_i) begin
      case (rsel)
        RSEL_CTRL: begin
          bus_rdata_o[TIME_LSB +: TIME_W] = frame_time;
          bus_rdata_o[2]                  = rx_err_flag;
          bus_rdata_o[1:0]                = line_st;
        end
        RSEL_IRQ:  bus_rdata_o[IRQ_N-1:0] = pend;
        RSEL_MASK: bus_rdata_o[IRQ_N-1:0] = mask;
        default:   bus_rdata_o = '0;
      endcase
    end
  end

  assign bus_reset_o = brst_q;
  assign tx_flush_o  = flush_q;

  p_flush_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    tx_flush_o |=> (!tx_flush_o || $past(wr_ctrl && bus_wdata_i[2])));
  p_ctrl_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ctrl |=> $stable(bus_reset_o));
  p_sof_pend_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sof_req_o |=> pend[IRQ_SOF]);
endmodule

// File: tb/uhost_csr_tb.sv
module uhost_csr_tb;
  localparam int FC = 200;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel = 1'b0, we = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [1:0]  ls = 2'b00;
  logic        rxe = 1'b0, xst = 1'b0, xdn = 1'b0, xer = 1'b0;
  logic        brst, sofr, flush, irq;

  int checks = 0, errors = 0;
  bit done = 1'b0, armed = 1'b0;

  always #5 clk = ~clk;

  uhost_csr #(.ADDR_W(8), .FRAME_CYCLES(FC), .TIME_W(16)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_sel_i(sel), .bus_we_i(we),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .line_state_i(ls), .rx_err_i(rxe), .xfer_start_i(xst),
    .xfer_done_i(xdn), .xfer_err_i(xer), .bus_reset_o(brst),
    .sof_req_o(sofr), .tx_flush_o(flush), .irq_o(irq)
  );

  // behavioural reference model
  int       m_cnt;
  bit       m_en, m_br, m_sof, m_flush, m_rxerr;
  bit [1:0] m_ls;
  bit [2:0] m_pend, m_mask;

  always @(posedge clk) begin
    int  w;
    bit  wr, nsof;
    bit [2:0] ack, evt;
    if (!rst_n) begin
      m_cnt = 0; m_en = 0; m_br = 0; m_sof = 0; m_flush = 0;
      m_rxerr = 0; m_ls = 0; m_pend = 0; m_mask = 0;
    end else begin
      w    = int'(addr[7:2]);
      wr   = sel && we;
      nsof = (m_cnt == FC - 1) && m_en && !m_br;
      evt  = {xer, xdn, m_sof};
      ack  = (wr && w == 1) ? wdata[2:0] : 3'b000;
      m_pend = (m_pend & ~ack) | evt;
      if (wr && w == 2) m_mask = wdata[2:0];
      m_flush = wr && w == 0 && wdata[2];
      if (wr && w == 0) begin m_br = wdata[0]; m_en = wdata[1]; end
      if (rxe) m_rxerr = 1; else if (xst) m_rxerr = 0;
      m_ls  = ls;
      m_cnt = (m_cnt == FC - 1) ? 0 : m_cnt + 1;
      m_sof = nsof;
    end
    armed = 1'b1;
  end

  function automatic logic [31:0] model_rdata();
    int w = int'(addr[7:2]);
    if (!sel) return 32'h0;
    case (w)
      0: return {m_cnt[15:0], 13'b0, m_rxerr, m_ls};
      1: return {29'b0, m_pend};
      2: return {29'b0, m_mask};
      default: return 32'h0;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (armed && !done) begin
      chk("R1 bus_reset_o", {31'b0, brst}, {31'b0, m_br});
      chk("R3 sof_req_o", {31'b0, sofr}, {31'b0, m_sof});
      chk("R9 tx_flush_o", {31'b0, flush}, {31'b0, m_flush});
      chk("R8 irq_o", {31'b0, irq}, {31'b0, |(m_pend & m_mask)});
      case (int'(addr[7:2]))
        0: chk("R2 R4 R5 status word", rdata, model_rdata());
        1: chk("R6 R7 pending word", rdata, model_rdata());
        2: chk("R8 mask word", rdata, model_rdata());
        default: chk("R10 unmapped word", rdata, model_rdata());
      endcase
    end
  end

  task automatic idle(input int n);
    repeat (n) begin
      @(posedge clk); #1;
      sel = 0; we = 0; rxe = 0; xst = 0; xdn = 0; xer = 0;
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    sel = 1; we = 1; addr = a; wdata = d;
    @(posedge clk); #1;
    we = 0; wdata = '0;
  endtask

  task automatic rd(input logic [7:0] a);
    @(posedge clk); #1;
    sel = 1; we = 0; addr = a;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 R2 reset state, then enable SOF and watch a wrap
    rd(8'h00); idle(1); rd(8'h00);
    wr(8'h08, 32'h7);
    wr(8'h00, 32'h2);
    rd(8'h04);
    repeat (FC + 20) @(posedge clk);
    // R7 ack and done event in the same cycle
    @(posedge clk); #1;
    sel = 1; we = 1; addr = 8'h04; wdata = 32'h7; xdn = 1;
    @(posedge clk); #1;
    we = 0; xdn = 0; wdata = 0;
    rd(8'h04); idle(2);
    // R9 flush pulse and R3 gating by bus reset
    wr(8'h00, 32'h7);
    rd(8'h00);
    repeat (FC + 10) @(posedge clk);
    wr(8'h00, 32'h2);
    // R5 rx error set/clear priority, R4 line state
    @(posedge clk); #1; rxe = 1; ls = 2'b10;
    @(posedge clk); #1; rxe = 0; xst = 1; ls = 2'b01;
    @(posedge clk); #1; rxe = 1; xst = 1; ls = 2'b11;
    @(posedge clk); #1; rxe = 0; xst = 0;
    // R10 unmapped write then reads
    wr(8'h0C, 32'hFFFF_FFFF);
    wr(8'h40, 32'hFFFF_FFFF);
    rd(8'h0C); rd(8'h08); rd(8'h04); rd(8'h00);
    // random mixed traffic
    for (int i = 0; i < 3000; i++) begin
      int k;
      @(posedge clk); #1;
      k     = $urandom_range(0, 5);
      addr  = (k == 0) ? 8'h00 : (k == 1) ? 8'h04 : (k == 2) ? 8'h08 :
              (k == 3) ? 8'h0C : (k == 4) ? 8'h41 : 8'h02;
      sel   = ($urandom_range(0, 7) != 0);
      we    = sel && ($urandom_range(0, 5) == 0);
      wdata = $urandom;
      if (we && addr[7:2] == 0 && $urandom_range(0, 3) != 0) wdata[0] = 1'b0;
      ls    = 2'($urandom_range(0, 3));
      rxe   = ($urandom_range(0, 15) == 0);
      xst   = ($urandom_range(0, 15) == 0);
      xdn   = ($urandom_range(0, 11) == 0);
      xer   = ($urandom_range(0, 19) == 0);
    end
    idle(3);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule